// File: doc/BRIEF.md
# I/O Window Address Decoder

The block sits behind a 512 KB memory-mapped I/O window and steers every access to one of nine peripheral register ports. Each access arrives as a window offset with read and write strobes, write data and an access size. The decoder splits the offset into a 4 KB page number and an in-page part. It asserts one target select and works out the register index that the selected peripheral expects. It passes write data and size through, and it returns the selected peripheral's read data through a register one cycle later.

Most targets take their index from a fixed bit field of the offset. Two cases differ. The DMA page is split again by channel. One serial page translates a legacy register layout through a 16-entry table before it falls back to the native layout. Accesses to pages that no target owns select nothing, so writes there are lost and reads there return zero.

Top module: `iodec_window`

## Requirements
- R1: The page number is offset bits 18:12. Page 0x00 selects the control register file (select bit 0), and its index is offset bits 7:0.
- R2: Page 0x08 is DMA space, and offset bits 11:8 name the channel. Channel 1 selects the floppy DMA registers (bit 1) and channel 8 selects the sound DMA registers (bit 2). For both, the index is offset bits 7:0. Any other channel selects nothing.
- R3: Three pages use offset bits 7:4 as the index: page 0x10 selects the SCSI port (bit 3), page 0x13 selects the serial port (bit 4) and page 0x15 selects the floppy port (bit 6).
- R4: Page 0x12 selects the serial port (bit 4). When offset bits 7:0 are below 16, the index is a table entry: with k equal to offset bits 4:1, the index is {k[1:0], k[3:2]}. Otherwise the index is offset bits 7:4.
- R5: Page 0x14 selects the sound port (bit 5), and its index is offset bits 11:0, which is the offset less 0x14000.
- R6: Pages 0x16 and 0x17 select the bus interface port (bit 7), and the index is (offset − 0x16000) >> 9.
- R7: Pages 0x60 and above select the NVRAM (bit 8), and the byte address is (offset − 0x60000) >> 4.
- R8: An access to any other page, or to an unlisted DMA channel, asserts no select and no write enable, and a read there returns zero.
- R9: At most one select bit is ever high. Exactly one is high during a mapped access, and none is high when neither strobe is high. Select and index follow the strobe within the same cycle.
- R10: On the clock edge where rd_i is high, the block captures the selected port's read data. The data appears on rdata_o with rvalid_o high in the next cycle. In a cycle after no read, rvalid_o is low and rdata_o is zero.
- R11: we_o is high only when wr_i is high and a target is selected. wdata_o and size_o carry wdata_i and size_i through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| offset_i | input | 19 | Byte offset inside the window |
| wdata_i | input | 32 | Write data |
| size_i | input | 3 | Access size in bytes |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| rdata_bus_i | input | 288 | Read data from the nine ports, port n in bits 32n+31:32n |
| sel_o | output | 9 | One-hot target select |
| idx_o | output | 13 | Register index for the selected port |
| wdata_o | output | 32 | Write data to the ports |
| size_o | output | 3 | Access size to the ports |
| we_o | output | 1 | Write enable, qualified by the select |
| rdata_o | output | 32 | Registered read data |
| rvalid_o | output | 1 | Read data valid |

## Verification
Select, index, write enable and the pass-through fields are combinational. The bench therefore drives each access just after a falling edge and samples these outputs one time unit later, within the same cycle. Read data passes through one register. The bench samples it at the next falling edge, which is after the single rising edge that loads it.

The bench models the peripherals as stubs that return a word built from the target number and the index they receive. The expected read word is then computed from the offset alone. The sweep covers every one of the 128 pages, using in-page offsets chosen to hit the legacy serial table, both DMA channels, unmapped DMA channels and the index field boundaries.

// File: rtl/iodec_pkg.sv
package iodec_pkg;
  localparam int NUM_TGT = 9;

  typedef enum logic [3:0] {
    TGT_CTRL    = 4'd0,
    TGT_DMA_FLP = 4'd1,
    TGT_DMA_SND = 4'd2,
    TGT_SCSI    = 4'd3,
    TGT_SERIAL  = 4'd4,
    TGT_SOUND   = 4'd5,
    TGT_FLOPPY  = 4'd6,
    TGT_BUSIF   = 4'd7,
    TGT_NVRAM   = 4'd8,
    TGT_NONE    = 4'd15
  } tgt_e;

  // legacy serial layout: swap the two halves of the 4-bit register number
  function automatic logic [3:0] legacy_remap(input logic [3:0] k);
    return {k[1:0], k[3:2]};
  endfunction
endpackage

// File: rtl/iodec_legacy_lut.sv
module iodec_legacy_lut #(
  parameter int KEY_W = 4
) (
  input  logic [KEY_W-1:0] key_i,
  output logic [KEY_W-1:0] val_o
);
  localparam int ENTRIES = 1 << KEY_W;

  logic [KEY_W-1:0] lut [ENTRIES];

  for (genvar k = 0; k < ENTRIES; k++) begin : g_lut
    assign lut[k] = iodec_pkg::legacy_remap(KEY_W'(k));
  end

  assign val_o = lut[key_i];
endmodule

// File: rtl/iodec_page_decode.sv
module iodec_page_decode
  import iodec_pkg::*;
#(
  parameter int OFS_W    = 19,
  parameter int PAGE_LSB = 12,
  parameter int IDX_W    = 13
) (
  input  logic [OFS_W-1:0] offset_i,
  output tgt_e             tgt_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int PAGE_W = OFS_W - PAGE_LSB;
  localparam logic [PAGE_W-1:0] PG_CTRL   = PAGE_W'(7'h00);
  localparam logic [PAGE_W-1:0] PG_DMA    = PAGE_W'(7'h08);
  localparam logic [PAGE_W-1:0] PG_SCSI   = PAGE_W'(7'h10);
  localparam logic [PAGE_W-1:0] PG_SER_LG = PAGE_W'(7'h12);
  localparam logic [PAGE_W-1:0] PG_SER    = PAGE_W'(7'h13);
  localparam logic [PAGE_W-1:0] PG_SOUND  = PAGE_W'(7'h14);
  localparam logic [PAGE_W-1:0] PG_FLOPPY = PAGE_W'(7'h15);
  localparam logic [PAGE_W-1:0] PG_BUSIF0 = PAGE_W'(7'h16);
  localparam logic [PAGE_W-1:0] PG_BUSIF1 = PAGE_W'(7'h17);
  localparam logic [PAGE_W-1:0] PG_NVRAM  = PAGE_W'(7'h60);
  localparam logic [3:0] CH_FLP = 4'h1;
  localparam logic [3:0] CH_SND = 4'h8;

  logic [PAGE_W-1:0] page;
  logic [3:0]        legacy_idx;
  logic [IDX_W-1:0]  native_idx;
  logic              legacy_hit;

  assign page       = offset_i[PAGE_LSB +: PAGE_W];
  assign native_idx = IDX_W'(offset_i[7:4]);
  assign legacy_hit = (offset_i[7:4] == 4'h0);

  iodec_legacy_lut #(.KEY_W(4)) u_lut (
    .key_i (offset_i[4:1]),
    .val_o (legacy_idx)
  );

  always_comb begin
    tgt_o = TGT_NONE;
    idx_o = '0;
    unique case (page)
      PG_CTRL: begin
        tgt_o = TGT_CTRL;
        idx_o = IDX_W'(offset_i[7:0]);
      end
      PG_DMA: begin
        idx_o = IDX_W'(offset_i[7:0]);
        if (offset_i[11:8] == CH_FLP)      tgt_o = TGT_DMA_FLP;
        else if (offset_i[11:8] == CH_SND) tgt_o = TGT_DMA_SND;
        else                               idx_o = '0;
      end
      PG_SCSI: begin
        tgt_o = TGT_SCSI;
        idx_o = native_idx;
      end
      PG_SER_LG: begin
        tgt_o = TGT_SERIAL;
        idx_o = legacy_hit ? IDX_W'(legacy_idx) : native_idx;
      end
      PG_SER: begin
        tgt_o = TGT_SERIAL;
        idx_o = native_idx;
      end
      PG_SOUND: begin
        tgt_o = TGT_SOUND;
        idx_o = IDX_W'(offset_i[PAGE_LSB-1:0]);
      end
      PG_FLOPPY: begin
        tgt_o = TGT_FLOPPY;
        idx_o = native_idx;
      end
      PG_BUSIF0, PG_BUSIF1: begin
        tgt_o = TGT_BUSIF;
        idx_o = IDX_W'(offset_i[PAGE_LSB:9]);
      end
      default: begin
        if (page >= PG_NVRAM) begin
          tgt_o = TGT_NVRAM;
          idx_o = IDX_W'(offset_i[OFS_W-3:4]);
        end
      end
    endcase
  end
endmodule

// File: rtl/iodec_sel_gen.sv
module iodec_sel_gen
  import iodec_pkg::*;
#(
  parameter int N_TGT = NUM_TGT
) (
  input  tgt_e             tgt_i,
  input  logic             access_i,
  output logic [N_TGT-1:0] sel_o
);
  for (genvar t = 0; t < N_TGT; t++) begin : g_sel
    assign sel_o[t] = access_i && (tgt_i == tgt_e'(t));
  end
endmodule

// File: rtl/iodec_rd_mux.sv
module iodec_rd_mux #(
  parameter int N_TGT  = 9,
  parameter int DATA_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rd_i,
  input  logic [N_TGT-1:0]        sel_i,
  input  logic [N_TGT*DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    rvalid_o
);
  logic [DATA_W-1:0] masked [N_TGT];
  logic [DATA_W-1:0] merged;

  for (genvar t = 0; t < N_TGT; t++) begin : g_mask
    assign masked[t] = sel_i[t] ? bus_i[t*DATA_W +: DATA_W] : '0;
  end

  always_comb begin
    merged = '0;
    for (int t = 0; t < N_TGT; t++) merged |= masked[t];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rdata_o  <= rd_i ? merged : '0;
      rvalid_o <= rd_i;
    end
  end
endmodule

// File: rtl/iodec_window.sv
module iodec_window
  import iodec_pkg::*;
#(
  parameter int OFS_W    = 19,
  parameter int PAGE_LSB = 12,
  parameter int IDX_W    = 13,
  parameter int DATA_W   = 32,
  parameter int SIZE_W   = 3,
  parameter int N_TGT    = NUM_TGT
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [OFS_W-1:0]        offset_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [SIZE_W-1:0]       size_i,
  input  logic                    rd_i,
  input  logic                    wr_i,
  input  logic [N_TGT*DATA_W-1:0] rdata_bus_i,
  output logic [N_TGT-1:0]        sel_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic [DATA_W-1:0]       wdata_o,
  output logic [SIZE_W-1:0]       size_o,
  output logic                    we_o,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    rvalid_o
);
  tgt_e             tgt;
  logic [IDX_W-1:0] idx;
  logic             access;

  assign access = rd_i | wr_i;

  iodec_page_decode #(
    .OFS_W(OFS_W), .PAGE_LSB(PAGE_LSB), .IDX_W(IDX_W)
  ) u_decode (
    .offset_i (offset_i),
    .tgt_o    (tgt),
    .idx_o    (idx)
  );

  iodec_sel_gen #(.N_TGT(N_TGT)) u_sel (
    .tgt_i    (tgt),
    .access_i (access),
    .sel_o    (sel_o)
  );

  iodec_rd_mux #(.N_TGT(N_TGT), .DATA_W(DATA_W)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd_i),
    .sel_i    (sel_o),
    .bus_i    (rdata_bus_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  assign idx_o   = access ? idx : '0;
  assign wdata_o = wdata_i;
  assign size_o  = size_i;
  assign we_o    = wr_i & (|sel_o);
endmodule

// File: rtl/iodec_window_chk.sv
module iodec_window_chk #(
  parameter int OFS_W    = 19,
  parameter int PAGE_LSB = 12,
  parameter int IDX_W    = 13,
  parameter int DATA_W   = 32,
  parameter int N_TGT    = 9
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [OFS_W-1:0]        offset_i,
  input logic                    rd_i,
  input logic                    wr_i,
  input logic [N_TGT*DATA_W-1:0] rdata_bus_i,
  input logic [N_TGT-1:0]        sel_o,
  input logic [IDX_W-1:0]        idx_o,
  input logic                    we_o,
  input logic [DATA_W-1:0]       rdata_o,
  input logic                    rvalid_o
);
  localparam int PAGE_W = OFS_W - PAGE_LSB;
  logic [PAGE_W-1:0] page;
  assign page = offset_i[PAGE_LSB +: PAGE_W];

  AST_SEL_ONEHOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i || wr_i) |-> (sel_o == '0) && !we_o); // R9
  AST_RVALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o); // R10
  AST_RVALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o && (rdata_o == '0)); // R10
  AST_RDATA_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_o[3]) |=> rdata_o == $past(rdata_bus_i[3*DATA_W +: DATA_W])); // R10
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_o == '0) |=> rdata_o == '0); // R8
  AST_NVRAM_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && page >= PAGE_W'(7'h60)) |-> sel_o[8]); // R7
  AST_BUSIF_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && (page == PAGE_W'(7'h16) || page == PAGE_W'(7'h17)))
      |-> sel_o[7] && idx_o == IDX_W'(offset_i[PAGE_LSB:9])); // R6
  AST_WE_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> wr_i && (sel_o != '0)); // R11
endmodule

bind iodec_window iodec_window_chk #(
  .OFS_W(OFS_W), .PAGE_LSB(PAGE_LSB), .IDX_W(IDX_W), .DATA_W(DATA_W), .N_TGT(N_TGT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .offset_i    (offset_i),
  .rd_i        (rd_i),
  .wr_i        (wr_i),
  .rdata_bus_i (rdata_bus_i),
  .sel_o       (sel_o),
  .idx_o       (idx_o),
  .we_o        (we_o),
  .rdata_o     (rdata_o),
  .rvalid_o    (rvalid_o)
);

// File: tb/iodec_window_bench.sv
`timescale 1ns/1ps
module iodec_window_bench;
  localparam int NT = 9;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [18:0]   offset = '0;
  logic [31:0]   wdata = '0;
  logic [2:0]    size = '0;
  logic          rd = 1'b0, wr = 1'b0;
  logic [NT*DW-1:0] bus;
  logic [NT-1:0] sel;
  logic [12:0]   idx;
  logic [31:0]   wdata_o, rdata;
  logic [2:0]    size_o;
  logic          we, rvalid;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // stub ports: selected port answers with its number and the index it sees
  for (genvar t = 0; t < NT; t++) begin : g_stub
    assign bus[t*DW +: DW] = sel[t] ? (32'hA000_0000 | (t << 16) | 32'(idx)) : 32'hDEAD_BEEF;
  end

  iodec_window u_iodec_window (
    .clk_i(clk), .rst_ni(rst_n), .offset_i(offset), .wdata_i(wdata), .size_i(size),
    .rd_i(rd), .wr_i(wr), .rdata_bus_i(bus), .sel_o(sel), .idx_o(idx),
    .wdata_o(wdata_o), .size_o(size_o), .we_o(we), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s ofs=%05h actual=%08h expected=%08h", req, offset, act, exp);
    end
  endtask

  function automatic void model(input int ofs, output int tgt, output int ix, output string req);
    int page, low, k;
    page = ofs >> 12; low = ofs & 'hFF; tgt = -1; ix = 0; req = "R8";
    if (page == 0) begin tgt = 0; ix = low; req = "R1"; end
    else if (page == 8) begin
      k = (ofs - 'h8000) >> 8;
      if (k == 1) begin tgt = 1; ix = low; req = "R2"; end
      else if (k == 8) begin tgt = 2; ix = low; req = "R2"; end
    end
    else if (page == 'h10) begin tgt = 3; ix = (ofs >> 4) & 15; req = "R3"; end
    else if (page == 'h12) begin
      tgt = 4; req = "R4";
      if (low < 16) begin k = (ofs >> 1) & 15; ix = ((k & 3) << 2) | (k >> 2); end
      else ix = (ofs >> 4) & 15;
    end
    else if (page == 'h13) begin tgt = 4; ix = (ofs >> 4) & 15; req = "R3"; end
    else if (page == 'h14) begin tgt = 5; ix = ofs - 'h14000; req = "R5"; end
    else if (page == 'h15) begin tgt = 6; ix = (ofs >> 4) & 15; req = "R3"; end
    else if (page == 'h16 || page == 'h17) begin tgt = 7; ix = (ofs - 'h16000) >> 9; req = "R6"; end
    else if (page >= 'h60) begin tgt = 8; ix = (ofs - 'h60000) >> 4; req = "R7"; end
  endfunction

  task automatic probe(input int ofs);
    int tgt, ix;
    string req;
    logic [31:0] exp_sel, exp_rd;
    model(ofs, tgt, ix, req);
    exp_sel = (tgt < 0) ? 32'h0 : (32'h1 << tgt);
    exp_rd  = (tgt < 0) ? 32'h0 : (32'hA000_0000 | (tgt << 16) | ix);
    // read
    offset = 19'(ofs); rd = 1'b1; wr = 1'b0;
    #1;
    check({req, " sel rd"}, 32'(sel), exp_sel);
    if (tgt >= 0) check({req, " idx"}, 32'(idx), 32'(ix));
    check("R9 onehot0", 32'($countones(sel) <= 1), 32'h1);
    @(negedge clk);
    check({req, " R10 rdata"}, rdata, exp_rd);
    check("R10 rvalid", 32'(rvalid), 32'h1);
    // write
    rd = 1'b0; wr = 1'b1; wdata = 32'(ofs) ^ 32'h5A5A_0000; size = 3'(ofs & 7);
    #1;
    check({req, " sel wr"}, 32'(sel), exp_sel);
    check("R11 we", 32'(we), 32'(tgt >= 0));
    check("R11 wdata", wdata_o, 32'(ofs) ^ 32'h5A5A_0000);
    check("R11 size", 32'(size_o), 32'(ofs & 7));
    @(negedge clk);
    check("R10 no read", 32'(rvalid), 32'h0);
    wr = 1'b0;
    #1;
    check("R9 idle", 32'(sel), 32'h0);
    @(negedge clk);
  endtask

  initial begin
    int lows [8] = '{'h000, 'h00E, 'h010, 'h1F6, 'h100, 'h800, 'hE3C, 'h20A};
    #20;
    check("R10 reset rvalid", 32'(rvalid), 32'h0);
    check("R10 reset rdata", rdata, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 128; p++)
      for (int j = 0; j < 8; j++)
        probe((p << 12) | lows[j]);
    // legacy serial table, every entry
    for (int k = 0; k < 16; k++) probe('h12000 | (k << 1));
    probe('h12010);
    probe('h7FFF0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule